// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an 8-bit up/down counter that drives one centre-aligned PWM output. The count climbs from 0 to 255, turns, falls back to 0 and repeats, so one period takes 510 timer ticks. The counter moves only on system-clock cycles where the external prescaler tick is high. The PWM output changes where the count meets a programmable compare value. On the rising half a match drives the output to its "up" level. On the falling half a match drives it to the opposite level. This places the pulse symmetrically around the bottom of the count.

Software writes the compare value into a staging register. The value takes effect only on the tick that leaves the top of the count, so a period never contains a mix of old and new thresholds. A compare value can leave 255, or a threshold can be skipped on the way up. In both cases the output is still brought to the up-match level at the turning point, with no match needed, so the waveform stays symmetric. A 2-bit mode field selects a disconnected, a non-inverted or an inverted output. A direction input gates the level onto the pin. A sticky flag marks each arrival at zero until it is cleared.

The counter is a two-state machine. COUNT_UP is entered at reset and through the TURN_BOTTOM transition, taken on a tick while falling from 1 to 0. COUNT_DOWN is entered through the TURN_TOP transition, taken on a tick while rising from 254 to 255.

Top module: `pcpwm_timer`

## Requirements
- R1: After synchronous reset the count is 0, the overflow flag is 0, and the PWM level and pin output are 0. The staged and the active compare values are both 0.
- R2: On each tick the count moves by one: up from 0 to 255, then down from 255 to 0, then up again. One full period is 510 ticks.
- R3: On a cycle with the tick low the count, the output level and the flag hold. The only exception is that the flag may be cleared.
- R4: The overflow flag is set on the tick that brings the count from 1 down to 0. It stays set until a cycle with the clear input high and no new set. If set and clear fall on the same cycle, set wins.
- R5: A compare write lands in the staging register. The active compare value loads from staging only on a tick taken while the count is 255. The active value is seen through the output level.
- R6: In mode 2 (non-inverted), with compare value C between 1 and 254, the level is 1 while the count is below C. At count C it is 0 when reached counting up and 1 when reached counting down. Above C it is 0.
- R7: In mode 3 (inverted) the level is the complement of the mode-2 level.
- R8: An active compare value of 0 gives a constant mode-2 level of 0. A value of 255 gives a constant mode-2 level of 1. Mode 3 gives the opposite constants.
- R9: When the active compare value changes from 255 to a value below 254, the mode-2 level drops to 0 on the first tick after the top, with no compare match.
- R10: Modes 0 and 1 hold the PWM level at 0.
- R11: The pin output equals the PWM level when the direction input is 1, and is 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer clock enable from the prescaler |
| out_mode | input | 2 | Output mode: 0/1 disconnected, 2 non-inverted, 3 inverted |
| cmp_wr | input | 1 | Write strobe for the staged compare value |
| cmp_wdata | input | 8 | Compare value to stage |
| pin_dir | input | 1 | 1 drives the PWM level onto the pin |
| ovf_clr | input | 1 | Clears the overflow flag |
| pwm_level | output | 1 | PWM level after mode selection |
| pin_out | output | 1 | Pin value, gated by direction |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong direction state shows at once on `count`, because the next tick steps the wrong way. The same fault also shifts the overflow flag by a whole half-period. A wrong output register or a mistimed compare load first shows on `pwm_level` at the next threshold or turning point. That can take up to 255 ticks, so each scenario runs at least one full period. This way every compare value passes through both the rising and the falling match, and through the top turn where the staged value takes effect.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic {
        ST_UP   = 1'b0,
        ST_DOWN = 1'b1
    } cnt_state_t;

    typedef enum logic [1:0] {
        OM_OFF_A  = 2'd0,
        OM_OFF_B  = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_t;

endpackage

// File: rtl/pcpwm_updown_counter.sv
module pcpwm_updown_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ovf_clr,
    output logic [W-1:0] count_o,
    output logic [W-1:0] next_count_o,
    output logic         step_up_o,
    output logic         at_top_o,
    output logic         ovf_o
);

    localparam logic [W-1:0] CNT_TOP  = '1;
    localparam logic [W-1:0] CNT_ONE  = W'(1);
    localparam logic [W-1:0] CNT_PEAK = CNT_TOP - CNT_ONE;

    cnt_state_t   state_q, state_d;
    logic [W-1:0] count_q, count_d;
    logic         ovf_q;
    logic         bottom_hit;

    // next-state and next-count logic
    always_comb begin
        state_d    = state_q;
        count_d    = count_q;
        bottom_hit = 1'b0;
        unique case (state_q)
            ST_UP: begin
                if (tick) begin
                    count_d = count_q + CNT_ONE;
                    if (count_q == CNT_PEAK) begin
                        state_d = ST_DOWN;          // TURN_TOP
                    end
                end
            end
            ST_DOWN: begin
                if (tick) begin
                    count_d = count_q - CNT_ONE;
                    if (count_q == CNT_ONE) begin
                        state_d    = ST_UP;         // TURN_BOTTOM
                        bottom_hit = 1'b1;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UP;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (bottom_hit) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        count_o      = count_q;
        next_count_o = count_d;
        step_up_o    = (state_q == ST_UP);
        at_top_o     = (count_q == CNT_TOP);
        ovf_o        = ovf_q;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((count_q == $past(count_q) + CNT_ONE) || (count_q == $past(count_q) - CNT_ONE))); // R2

    AST_TURN_TOP: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == CNT_TOP) |=> (count_q == CNT_PEAK)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q); // R4

    AST_BOTTOM_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == CNT_ONE && state_q == ST_DOWN) |=> (ovf_q && count_q == '0)); // R4

endmodule

// File: rtl/pcpwm_cmp_buffer.sv
module pcpwm_cmp_buffer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    input  logic [W-1:0] count,
    input  logic         tick,
    output logic [W-1:0] cmp_next_o,
    output logic [W-1:0] cmp_act_o
);

    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] stage_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act_q   <= '0;
        end else begin
            if (load) begin
                act_q <= stage_q;
            end
            if (wr_en) begin
                stage_q <= wr_data;
            end
        end
    end

    always_comb begin
        cmp_next_o = load ? stage_q : act_q;
        cmp_act_o  = act_q;
    end

    AST_LOAD_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (act_q != $past(act_q)) |-> ($past(count) == CNT_TOP && $past(tick))); // R5

endmodule

// File: rtl/pcpwm_wave.sv
module pcpwm_wave
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         step_up,
    input  logic [W-1:0] count,
    input  logic [W-1:0] next_count,
    input  logic         leaving_top,
    input  logic [W-1:0] cmp_next,
    input  logic [W-1:0] cmp_act,
    input  out_mode_t    mode,
    input  logic         pin_dir,
    output logic         pwm_o,
    output logic         pin_o
);

    localparam logic [W-1:0] CMP_TOP = '1;

    logic act_q, act_d;

    // level update rules, applied only on timer ticks
    always_comb begin
        act_d = act_q;
        if (tick) begin
            if (cmp_next == '0) begin
                act_d = 1'b0;
            end else if (cmp_next == CMP_TOP) begin
                act_d = 1'b1;
            end else if (next_count == cmp_next) begin
                act_d = ~step_up;                   // up match clears, down match sets
            end else if (next_count == CMP_TOP || leaving_top) begin
                act_d = 1'b0;                       // forced up-match level at the turn
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_d;
        end
    end

    // mode decode and pin gating
    always_comb begin
        unique case (mode)
            OM_OFF_A:  pwm_o = 1'b0;
            OM_OFF_B:  pwm_o = 1'b0;
            OM_NONINV: pwm_o = act_q;
            OM_INV:    pwm_o = ~act_q;
        endcase
        pin_o = pin_dir & pwm_o;
    end

    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == '0) |-> !act_q); // R8

    AST_MAX_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == CMP_TOP) |-> act_q); // R8

    AST_TOP_UPLEVEL: assert property (@(posedge clk) disable iff (rst)
        (count == CMP_TOP && cmp_act != CMP_TOP) |-> !act_q); // R9

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [1:0]       out_mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             pin_dir,
    input  logic             ovf_clr,
    output logic             pwm_level,
    output logic             pin_out,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);

    logic [CNT_W-1:0] cnt_now;
    logic [CNT_W-1:0] cnt_next;
    logic             step_up;
    logic             at_top;
    logic             cmp_load;
    logic [CNT_W-1:0] cmp_next;
    logic [CNT_W-1:0] cmp_act;
    out_mode_t        mode_e;

    assign mode_e   = out_mode_t'(out_mode);
    assign cmp_load = tick_en & at_top;
    assign count    = cnt_now;

    pcpwm_updown_counter #(.W(CNT_W)) u_counter (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_en),
        .ovf_clr      (ovf_clr),
        .count_o      (cnt_now),
        .next_count_o (cnt_next),
        .step_up_o    (step_up),
        .at_top_o     (at_top),
        .ovf_o        (ovf_flag)
    );

    pcpwm_cmp_buffer #(.W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cmp_wr),
        .wr_data    (cmp_wdata),
        .load       (cmp_load),
        .count      (cnt_now),
        .tick       (tick_en),
        .cmp_next_o (cmp_next),
        .cmp_act_o  (cmp_act)
    );

    pcpwm_wave #(.W(CNT_W)) u_wave (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_en),
        .step_up     (step_up),
        .count       (cnt_now),
        .next_count  (cnt_next),
        .leaving_top (at_top),
        .cmp_next    (cmp_next),
        .cmp_act     (cmp_act),
        .mode        (mode_e),
        .pin_dir     (pin_dir),
        .pwm_o       (pwm_level),
        .pin_o       (pin_out)
    );

endmodule

// File: tb/pcpwm_timer_bench.sv
`timescale 1ns/1ps
module pcpwm_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] out_mode = 2'd0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       pin_dir = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       pwm_level, pin_out, ovf_flag;
    logic [7:0] count;

    always #10 clk = ~clk;   // 50 MHz

    pcpwm_timer u_pcpwm_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .out_mode(out_mode),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .pin_dir(pin_dir),
        .ovf_clr(ovf_clr), .pwm_level(pwm_level), .pin_out(pin_out),
        .count(count), .ovf_flag(ovf_flag)
    );

    typedef struct {
        logic [7:0] cnt;
        logic       lvl;
        logic       pin;
        logic       flg;
        string      ctag;
        string      ltag;
    } exp_t;

    exp_t q[$];
    int   nchk = 0;
    int   nfail = 0;
    bit   done = 0;

    // reference model state
    logic [7:0] m_cnt = 0, m_stage = 0, m_act = 0;
    logic       m_down = 0, m_last_down = 0, m_flg = 0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_dir = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: drive one cycle and push the expected post-edge values
    task automatic cycle(input logic t, input logic wr, input logic [7:0] wd, input logic clr);
        exp_t       e;
        logic       load, a, lv;
        logic [7:0] c_new, prev;
        @(negedge clk);
        tick_en = t; cmp_wr = wr; cmp_wdata = wd; ovf_clr = clr;
        out_mode = cfg_mode; pin_dir = cfg_dir;
        load  = t && (m_cnt == 8'hFF);
        prev  = m_act;
        c_new = load ? m_stage : m_act;
        if (wr) m_stage = wd;
        if (t && m_down && m_cnt == 8'd1) m_flg = 1'b1;
        else if (clr) m_flg = 1'b0;
        if (t) begin
            if (!m_down) begin
                m_cnt = m_cnt + 8'd1;
                if (m_cnt == 8'hFF) m_down = 1'b1;
                m_last_down = 1'b0;
            end else begin
                m_cnt = m_cnt - 8'd1;
                if (m_cnt == 8'd0) m_down = 1'b0;
                m_last_down = 1'b1;
            end
        end
        m_act = c_new;
        if (m_act == 8'hFF) a = 1'b1;
        else if (m_act == 8'd0) a = 1'b0;
        else a = m_last_down ? (m_cnt <= m_act) : (m_cnt < m_act);
        lv = (cfg_mode == 2'd2) ? a : (cfg_mode == 2'd3) ? ~a : 1'b0;
        e.cnt = m_cnt; e.lvl = lv; e.pin = lv & cfg_dir; e.flg = m_flg;
        e.ctag = t ? "R2" : "R3";
        if (cfg_mode < 2'd2) e.ltag = "R10";
        else if (load && prev == 8'hFF && c_new != 8'hFF) e.ltag = "R9";
        else if (load && c_new != prev) e.ltag = "R5";
        else if (m_act == 8'd0 || m_act == 8'hFF) e.ltag = "R8";
        else if (cfg_mode == 2'd2) e.ltag = "R6";
        else e.ltag = "R7";
        q.push_back(e);
    endtask

    task automatic run(input int n, input int tick_every, input int clr_every);
        for (int i = 0; i < n; i++) begin
            cycle((i % tick_every) == 0, 1'b0, 8'd0,
                  (clr_every > 0) && ((i % clr_every) == clr_every - 1));
        end
    endtask

    // monitor: pop and compare away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(count == e.cnt, e.ctag, count, e.cnt);
                chk(pwm_level == e.lvl, e.ltag, pwm_level, e.lvl);
                chk(pin_out == e.pin, "R11", pin_out, e.pin);
                chk(ovf_flag == e.flg, "R4", ovf_flag, e.flg);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #5;
        // R1: reset state
        chk(count == 8'd0, "R1", count, 0);
        chk(ovf_flag == 1'b0, "R1", ovf_flag, 0);
        chk(pwm_level == 1'b0, "R1", pwm_level, 0);
        chk(pin_out == 1'b0, "R1", pin_out, 0);

        // R6 non-inverted, compare 100, flag clears every 7 cycles (R4)
        cfg_mode = 2'd2; cfg_dir = 1'b1;
        cycle(1'b1, 1'b1, 8'd100, 1'b0);
        run(1100, 1, 7);
        // R3 sparse ticks
        run(400, 3, 0);
        // R7 inverted, compare 30 staged mid-period (R5)
        cfg_mode = 2'd3;
        cycle(1'b1, 1'b1, 8'd30, 1'b0);
        run(600, 1, 0);
        // R8 extremes in both modes
        cycle(1'b1, 1'b1, 8'd0, 1'b0);
        run(600, 1, 0);
        cfg_mode = 2'd2;
        cycle(1'b1, 1'b1, 8'd255, 1'b0);
        run(600, 1, 0);
        // R9 leave MAX; also down match at 254 afterwards
        cycle(1'b1, 1'b1, 8'd60, 1'b0);
        run(600, 1, 13);
        cycle(1'b1, 1'b1, 8'd254, 1'b0);
        run(600, 1, 0);
        // R10 disconnected modes, R11 pin gating
        cfg_mode = 2'd0;
        run(150, 1, 0);
        cfg_mode = 2'd1;
        run(150, 1, 0);
        cfg_mode = 2'd2; cfg_dir = 1'b0;
        run(300, 1, 0);
        cfg_dir = 1'b1;
        run(100, 2, 5);

        @(negedge clk);
        tick_en = 1'b0; cmp_wr = 1'b0; ovf_clr = 1'b0;
        repeat (3) @(posedge clk);
        #7;
        finish_run();
    end

endmodule